// File: doc/BRIEF.md
# Tracking Error Built-In-Test Monitor

This block sits beside the tracking loop of an angle converter and turns its health into one fault bit. Each clock it takes one sample: the signed difference between the measured angle and the tracked digital angle, counted in LSBs of whichever resolution is selected, the resolution select itself, and two loss indicators, one for the signal inputs and one for the excitation reference. A large error shows up during a big step, during an over-speed slew that the loop cannot follow, or when the loop has failed. Either loss indicator also raises the fault.

The error is brought to one internal unit before it is compared. A coarse LSB (14-bit mode) is four fine LSBs (16-bit mode), so a coarse sample is shifted left and compared against a threshold shifted by the same amount. The fault sets on the first bad sample. It clears only after the loop has stayed near null for a set number of samples in a row. A bad sample starts that count over, and so does a resolution change, because the error scale has just changed.

Top module: `trk_fault_mon`

## Requirements
- R1: After reset `fault_o` is 0, and the monitor takes the resolution as 16-bit (`res_fine` = 1).
- R2: With `res_fine` = 1, a sample whose error magnitude exceeds TRIP_LSB (default 65) makes `fault_o` 1 on the clock edge that takes the sample. `fault_o` = 1 means fault and 0 means normal.
- R3: The comparison is strict and symmetric in sign. An error of +65 or -65 does not trip. An error of +66 or -66 does.
- R4: With `res_fine` = 0 the error is in 14-bit LSBs. It is scaled by 4 (COARSE_SHIFT = 2) against a threshold scaled the same way, so it trips above 65 coarse LSBs and not at 65.
- R5: `sig_loss` = 1 sets `fault_o` on that edge whatever the error is.
- R6: `ref_loss` = 1 sets `fault_o` on that edge, alone or together with `sig_loss`.
- R7: Once set, `fault_o` stays 1 until SETTLE_CNT (default 8) clean samples in a row have been taken. A clean sample has no loss flag set and a magnitude at or below the threshold. `fault_o` falls on the edge that takes the last of those samples.
- R8: A bad sample taken while the fault is held sets the clean count back to zero.
- R9: While the fault is held, a sample whose `res_fine` differs from the previous sample is not counted, and it sets the clean count back to zero.
- R10: The most negative error code (-2^(ERR_W-1)) trips in both modes with no wrap-around. The most positive code trips in coarse mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trk_err | input | ERR_W | Signed tracking error in LSBs of the selected resolution |
| res_fine | input | 1 | 1 = 16-bit LSBs, 0 = 14-bit LSBs |
| sig_loss | input | 1 | Signal inputs lost |
| ref_loss | input | 1 | Reference lost |
| fault_o | output | 1 | 1 = fault, 0 = normal |

## Verification
The bench works the threshold edge from both sides and in both resolutions. A comparison that is not strict, or that loses the sign, would trip at ±65 or stay quiet at -66. A design that scaled only the error, or only the threshold, would trip at the wrong coarse count. The release path gets clean runs that a bad sample cuts off after four samples, and runs that a resolution flip cuts off. A counter that never restarts, or that still counts the flip sample, would drop the fault early. The most negative error code goes in during both modes, to catch a magnitude that wraps to zero and never trips.

// File: rtl/trkmon_pkg.sv
`timescale 1ns/1ps
package trkmon_pkg;
   typedef enum logic {
      RES_COARSE = 1'b0,
      RES_FINE   = 1'b1
   } res_e;

   // width needed to hold a magnitude of a signed ERR_W value after scaling
   function automatic int unsigned mag_width(int unsigned err_w, int unsigned shift);
      return err_w + 1 + shift;
   endfunction
endpackage

// File: rtl/trkmon_scale.sv
`timescale 1ns/1ps
module trkmon_scale
   import trkmon_pkg::*;
#(
   parameter int unsigned ERR_W  = 12,
   parameter int unsigned SHIFT  = 2,
   parameter bit          IN_REG = 1'b0,
   localparam int unsigned MAG_W = mag_width(ERR_W, SHIFT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ERR_W-1:0] err_i,
   input  logic             res_i,
   input  logic             sig_loss_i,
   input  logic             ref_loss_i,
   output logic [MAG_W-1:0] mag_o,
   output logic             res_o,
   output logic             loss_o
);
   localparam int unsigned EXT_W = ERR_W + 1;

   generate
      if (ERR_W < 4) begin : g_bad_w
         $error("trkmon_scale: ERR_W must be at least 4");
      end
      if (SHIFT < 1) begin : g_bad_s
         $error("trkmon_scale: SHIFT must be at least 1");
      end
   endgenerate

   logic [EXT_W-1:0] ext;
   logic [EXT_W-1:0] mag_raw;
   logic [MAG_W-1:0] mag_scaled;
   logic             loss_raw;

   // one extra bit so the most negative code keeps its magnitude
   assign ext      = {err_i[ERR_W-1], err_i};
   assign mag_raw  = err_i[ERR_W-1] ? (~ext + EXT_W'(1)) : ext;
   assign loss_raw = sig_loss_i | ref_loss_i;

   always_comb begin
      if (res_e'(res_i) == RES_FINE) begin
         mag_scaled = {{SHIFT{1'b0}}, mag_raw};
      end else begin
         mag_scaled = {mag_raw, {SHIFT{1'b0}}};
      end
   end

   generate
      if (IN_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mag_o  <= '0;
               res_o  <= 1'b1;
               loss_o <= 1'b0;
            end else begin
               mag_o  <= mag_scaled;
               res_o  <= res_i;
               loss_o <= loss_raw;
            end
         end
      end else begin : g_pass
         assign mag_o  = mag_scaled;
         assign res_o  = res_i;
         assign loss_o = loss_raw;
      end
   endgenerate

   // coarse samples land on multiples of the scale step
   AST_COARSE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (!res_o) |-> (mag_o[SHIFT-1:0] == '0)); // R4

endmodule

// File: rtl/trkmon_cmp.sv
`timescale 1ns/1ps
module trkmon_cmp
   import trkmon_pkg::*;
#(
   parameter int unsigned MAG_W    = 15,
   parameter int unsigned TRIP_LSB = 65,
   parameter int unsigned SHIFT    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [MAG_W-1:0] mag_i,
   input  logic             res_i,
   input  logic             loss_i,
   output logic             bad_o
);
   localparam logic [MAG_W-1:0] THR_FINE   = MAG_W'(TRIP_LSB);
   localparam logic [MAG_W-1:0] THR_COARSE = MAG_W'(TRIP_LSB << SHIFT);

   generate
      if ((TRIP_LSB << SHIFT) >= (1 << (MAG_W - 1))) begin : g_bad_trip
         $error("trkmon_cmp: TRIP_LSB does not fit the magnitude width");
      end
   endgenerate

   logic [MAG_W-1:0] thr;
   logic             over;

   assign thr   = (res_e'(res_i) == RES_FINE) ? THR_FINE : THR_COARSE;
   assign over  = mag_i > thr;
   assign bad_o = over | loss_i;

   // a magnitude at or below the fine threshold is never judged bad without a loss
   AST_SMALL_IS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      ((mag_i <= THR_FINE) && !loss_i) |-> !bad_o); // R3

endmodule

// File: rtl/trkmon_release.sv
`timescale 1ns/1ps
module trkmon_release #(
   parameter int unsigned SETTLE_CNT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bad_i,
   input  logic res_i,
   output logic fault_o
);
   generate
      if (SETTLE_CNT < 1) begin : g_bad_settle
         $error("trkmon_release: SETTLE_CNT must be at least 1");
      end
   endgenerate

   logic res_q;
   logic res_chg;
   logic fault_q;

   assign res_chg = res_i != res_q;
   assign fault_o = fault_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= 1'b1;
      end else begin
         res_q <= res_i;
      end
   end

   generate
      if (SETTLE_CNT == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               fault_q <= 1'b0;
            end else begin
               fault_q <= bad_i | (fault_q & res_chg);
            end
         end
      end else begin : g_count
         localparam int unsigned CNT_W = $clog2(SETTLE_CNT);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CNT - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               fault_q <= 1'b0;
               cnt_q   <= '0;
            end else if (bad_i) begin
               fault_q <= 1'b1;
               cnt_q   <= '0;
            end else if (fault_q) begin
               if (res_chg) begin
                  cnt_q <= '0;
               end else if (cnt_q == LAST) begin
                  fault_q <= 1'b0;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
         end

         AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= LAST); // R7
         AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (!fault_q) |-> (cnt_q == '0)); // R7
         AST_BAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
            bad_i |=> (cnt_q == '0)); // R8
      end
   endgenerate

   AST_BAD_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
      bad_i |=> fault_q); // R2
   AST_CLEAR_AFTER_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault_q) |-> $past(!bad_i)); // R7
   AST_RESCHG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_q && res_chg) |=> fault_q); // R9

endmodule

// File: rtl/trk_fault_mon.sv
`timescale 1ns/1ps
module trk_fault_mon
   import trkmon_pkg::*;
#(
   parameter int unsigned ERR_W        = 12,
   parameter int unsigned TRIP_LSB     = 65,
   parameter int unsigned COARSE_SHIFT = 2,
   parameter int unsigned SETTLE_CNT   = 8,
   parameter bit          IN_REG       = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ERR_W-1:0] trk_err,
   input  logic             res_fine,
   input  logic             sig_loss,
   input  logic             ref_loss,
   output logic             fault_o
);
   localparam int unsigned MAG_W = mag_width(ERR_W, COARSE_SHIFT);

   logic [MAG_W-1:0] mag;
   logic             res_s;
   logic             loss_s;
   logic             bad;

   trkmon_scale #(
      .ERR_W (ERR_W),
      .SHIFT (COARSE_SHIFT),
      .IN_REG(IN_REG)
   ) u_scale (
      .clk       (clk),
      .rst_n     (rst_n),
      .err_i     (trk_err),
      .res_i     (res_fine),
      .sig_loss_i(sig_loss),
      .ref_loss_i(ref_loss),
      .mag_o     (mag),
      .res_o     (res_s),
      .loss_o    (loss_s)
   );

   trkmon_cmp #(
      .MAG_W   (MAG_W),
      .TRIP_LSB(TRIP_LSB),
      .SHIFT   (COARSE_SHIFT)
   ) u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .mag_i (mag),
      .res_i (res_s),
      .loss_i(loss_s),
      .bad_o (bad)
   );

   trkmon_release #(
      .SETTLE_CNT(SETTLE_CNT)
   ) u_rel (
      .clk    (clk),
      .rst_n  (rst_n),
      .bad_i  (bad),
      .res_i  (res_s),
      .fault_o(fault_o)
   );

   generate
      if (!IN_REG) begin : g_port_chk
         AST_LOSS_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
            (sig_loss || ref_loss) |=> fault_o); // R5 R6
      end
   endgenerate

endmodule

// File: tb/trk_fault_mon_test.sv
`timescale 1ns/1ps
module trk_fault_mon_test;
   localparam int ERR_W  = 12;
   localparam int TRIP   = 65;
   localparam int SETTLE = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [ERR_W-1:0] trk_err = '0;
   logic             res_fine = 1'b1;
   logic             sig_loss = 1'b0;
   logic             ref_loss = 1'b0;
   logic             fault_o;

   int tests = 0;
   int fails = 0;
   bit done = 0;

   bit    exp_q[$];
   string tag_q[$];

   // reference model state
   bit m_fault = 0;
   int m_cnt = 0;
   bit m_res = 1;

   always #2.5 clk = ~clk;

   trk_fault_mon #(.ERR_W(ERR_W), .TRIP_LSB(TRIP), .SETTLE_CNT(SETTLE)) uut (
      .clk(clk), .rst_n(rst_n), .trk_err(trk_err), .res_fine(res_fine),
      .sig_loss(sig_loss), .ref_loss(ref_loss), .fault_o(fault_o)
   );

   task automatic check(input bit act, input bit exp, input string tag);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: fault_o=%0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   // driver: applies one sample and pushes the expected fault after its edge
   task automatic put(input int err, input bit res, input bit sl, input bit rl, input string tag);
      int  mag;
      bit  bad;
      @(negedge clk);
      trk_err  = ERR_W'(err);
      res_fine = res;
      sig_loss = sl;
      ref_loss = rl;
      mag = (err < 0) ? -err : err;
      bad = sl | rl | (mag > TRIP);
      if (bad) begin
         m_fault = 1; m_cnt = 0;
      end else if (m_fault) begin
         if (res != m_res) m_cnt = 0;
         else if (m_cnt == SETTLE - 1) begin m_fault = 0; m_cnt = 0; end
         else m_cnt++;
      end
      m_res = res;
      exp_q.push_back(m_fault);
      tag_q.push_back(tag);
   endtask

   task automatic clean_run(input int n, input bit res, input string tag);
      for (int i = 0; i < n; i++) put(i % 40 - 20, res, 0, 0, tag);
   endtask

   // monitor: compares each result just after the edge that produced it
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) check(fault_o, exp_q.pop_front(), tag_q.pop_front());
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(fault_o, 1'b0, "R1 reset");
      rst_n = 1'b1;
      check(fault_o, 1'b0, "R1 after reset");

      put(0, 1, 0, 0, "R2 zero error");
      put(65, 1, 0, 0, "R3 +65 no trip");
      put(-65, 1, 0, 0, "R3 -65 no trip");
      put(66, 1, 0, 0, "R2 +66 trips");
      clean_run(SETTLE, 1, "R7 settle release");
      put(-66, 1, 0, 0, "R3 -66 trips");
      clean_run(4, 1, "R8 partial run");
      put(70, 1, 0, 0, "R8 bad restarts");
      clean_run(SETTLE, 1, "R8 full run after restart");

      put(65, 0, 0, 0, "R4 coarse 65 no trip");
      put(-65, 0, 0, 0, "R4 coarse -65 no trip");
      put(66, 0, 0, 0, "R4 coarse 66 trips");
      clean_run(3, 0, "R9 coarse partial");
      put(0, 1, 0, 0, "R9 res flip not counted");
      clean_run(SETTLE, 1, "R9 full run after flip");
      put(0, 0, 0, 0, "R9 flip while idle");
      put(0, 1, 0, 0, "R9 flip back while idle");

      put(0, 1, 1, 0, "R5 sig loss");
      put(0, 1, 1, 0, "R5 sig loss held");
      clean_run(SETTLE, 1, "R5 release after sig loss");
      put(3, 1, 0, 1, "R6 ref loss");
      clean_run(2, 1, "R6 partial");
      put(0, 1, 1, 1, "R6 both losses");
      clean_run(SETTLE, 1, "R6 release after both");

      put(-2048, 1, 0, 0, "R10 most negative fine");
      clean_run(SETTLE, 1, "R10 release");
      put(-2048, 0, 0, 0, "R10 most negative coarse");
      clean_run(SETTLE, 0, "R10 release coarse");
      put(2047, 0, 0, 0, "R10 most positive coarse");
      clean_run(SETTLE, 0, "R10 release coarse 2");

      for (int k = 0; k < 400; k++) begin
         int e;
         e = $urandom_range(150, 0) - 75;
         if ($urandom_range(5, 0) != 0) e = e / 4;
         put(e, ($urandom_range(15, 0) != 0) ? res_fine : ~res_fine,
             ($urandom_range(40, 0) == 0), ($urandom_range(40, 0) == 0), "R8 mixed sweep");
      end

      repeat (3) @(negedge clk);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule